// File: doc/BRIEF.md
# Repeat-String Micro-Op Sequencer

This block is the single complex-decode slot of an instruction decoder. It takes a decoded instruction that carries a repeat flag, an operation kind, and the current count, source pointer and destination pointer. A repeated byte copy or byte fill becomes a loop that emits micro-ops to the backend, one per cycle. Each micro-op is handed over through a valid/ready pair. The loop ends when the count reaches zero.

A byte copy issues four micro-ops per iteration and a byte fill issues three. Every micro-op shows the count and pointer values that hold at the moment it is presented. The block refuses an instruction that has no repeat flag, and it refuses any kind it cannot repeat. Those instructions belong to the simple decoders. Because one repeated instruction keeps the backend busy for many cycles, a single copy of this sequencer is enough.

Top module: `rep_seq`

## Requirements
- R1: After reset, `busy`, `uop_valid` and `in_refuse` are all 0.
- R2: An instruction is accepted only if `in_rep` is 1 and `in_kind` is 2'b01 (copy) or 2'b10 (fill). Any other instruction offered while idle raises `in_refuse` for exactly the cycle after it is offered. It does not raise `busy` and produces no micro-op.
- R3: A copy with count N emits exactly 4·N micro-ops, repeating LOAD (3'd1), STORE (3'd2), PTRINC (3'd3), CNTDEC (3'd4) in that order.
- R4: A fill with count N emits exactly 3·N micro-ops, repeating STORE, PTRINC, CNTDEC in that order.
- R5: When a PTRINC micro-op is handed over, a copy adds one to both the source and the destination pointer. A fill adds one to the destination pointer only. Each micro-op's `uop_src` and `uop_dst` show the pointer values at the moment it is presented.
- R6: When a CNTDEC micro-op is handed over, the count drops by one. The loop stops after the CNTDEC that brings the count to zero.
- R7: An accepted instruction with count 0 emits no micro-op. `busy` is high for exactly two cycles.
- R8: While `uop_valid` is 1 and `uop_ready` is 0, the micro-op and all of its fields stay unchanged. No micro-op is dropped or duplicated.
- R9: `busy` rises in the cycle after acceptance and falls after the last micro-op is handed over. Input offered while `busy` is high is ignored: it causes no refusal and no extra micro-op.
- R10: `uop_valid` is 1 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_rep | input | 1 | Repeat flag present |
| in_kind | input | 2 | Operation kind: 01 copy, 10 fill, other not repeatable |
| in_cnt | input | CW | Initial count |
| in_src | input | AW | Initial source pointer |
| in_dst | input | AW | Initial destination pointer |
| in_refuse | output | 1 | Pulse: offered instruction rejected |
| busy | output | 1 | Loop in progress |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Backend accepts micro-op |
| uop_op | output | 3 | Micro-op code |
| uop_src | output | AW | Source pointer value for this micro-op |
| uop_dst | output | AW | Destination pointer value for this micro-op |
| uop_cnt | output | CW | Count value for this micro-op |

## Verification
The hardest situations to reach are a backend stall on the last CNTDEC, where the loop must finish exactly once, and a new instruction arriving while a loop is still running. The bench drives `uop_ready` from a pseudo-random sequence, so stalls land on every micro-op kind, including the final one. While the sequencer is busy, it offers both a legal instruction and an illegal one. The scoreboard then flags any extra micro-op, and a port check flags any refusal pulse.

// File: rtl/rep_seq_pkg.sv
package rep_seq_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_COPY  = 2'd1,
    KIND_FILL  = 2'd2,
    KIND_OTHER = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    UOP_NOP    = 3'd0,
    UOP_LOAD   = 3'd1,
    UOP_STORE  = 3'd2,
    UOP_PTRINC = 3'd3,
    UOP_CNTDEC = 3'd4
  } uop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_EMIT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/rep_seq_filter.sv
module rep_seq_filter
  import rep_seq_pkg::*;
(
  input  logic       rep,
  input  logic [1:0] kind,
  output logic       legal,
  output logic       is_copy
);
  always_comb begin
    is_copy = (kind == KIND_COPY);
    legal   = rep && ((kind == KIND_COPY) || (kind == KIND_FILL));
  end
endmodule

// File: rtl/rep_seq_state.sv
module rep_seq_state #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          ld_copy,
  input  logic [CW-1:0] ld_cnt,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic          inc,
  input  logic          dec,
  output logic          copy_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic          cnt_zero,
  output logic          cnt_last
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      copy_q <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else if (load) begin
      copy_q <= ld_copy;
      cnt_q  <= ld_cnt;
      src_q  <= ld_src;
      dst_q  <= ld_dst;
    end else begin
      if (inc) begin
        dst_q <= dst_q + PTR_ONE;
        if (copy_q) src_q <= src_q + PTR_ONE;
      end
      if (dec) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  always_comb begin
    cnt_zero = (cnt_q == '0);
    cnt_last = (cnt_q == CNT_ONE);
  end
endmodule

// File: rtl/rep_seq_fsm.sv
module rep_seq_fsm
  import rep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       legal,
  input  logic       copy_q,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       uop_ready,
  output logic       accept,
  output logic       refuse_q,
  output logic       busy,
  output logic       valid_q,
  output logic [2:0] op_out,
  output logic       inc,
  output logic       dec
);
  st_e  st_q;
  uop_e op_q;
  logic fire;

  always_comb begin
    accept = (st_q == ST_IDLE) && in_valid && legal;
    fire   = valid_q && uop_ready;
    inc    = fire && (op_q == UOP_PTRINC);
    dec    = fire && (op_q == UOP_CNTDEC);
    busy   = (st_q != ST_IDLE);
    op_out = op_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      op_q     <= UOP_NOP;
      valid_q  <= 1'b0;
      refuse_q <= 1'b0;
    end else begin
      refuse_q <= (st_q == ST_IDLE) && in_valid && !legal;
      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_CHECK;
        ST_CHECK: begin
          if (cnt_zero) begin
            st_q <= ST_DONE;
          end else begin
            st_q    <= ST_EMIT;
            valid_q <= 1'b1;
            op_q    <= copy_q ? UOP_LOAD : UOP_STORE;
          end
        end
        ST_EMIT: begin
          if (fire) begin
            case (op_q)
              UOP_LOAD:   op_q <= UOP_STORE;
              UOP_STORE:  op_q <= UOP_PTRINC;
              UOP_PTRINC: op_q <= UOP_CNTDEC;
              default: begin
                if (cnt_last) begin
                  valid_q <= 1'b0;
                  op_q    <= UOP_NOP;
                  st_q    <= ST_DONE;
                end else begin
                  op_q <= copy_q ? UOP_LOAD : UOP_STORE;
                end
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rep_seq.sv
module rep_seq #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_rep,
  input  logic [1:0]    in_kind,
  input  logic [CW-1:0] in_cnt,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  output logic          in_refuse,
  output logic          busy,
  output logic          uop_valid,
  input  logic          uop_ready,
  output logic [2:0]    uop_op,
  output logic [AW-1:0] uop_src,
  output logic [AW-1:0] uop_dst,
  output logic [CW-1:0] uop_cnt
);
  logic legal, is_copy, accept, inc, dec, copy_q, cnt_zero, cnt_last;

  rep_seq_filter u_filter (
    .rep     (in_rep),
    .kind    (in_kind),
    .legal   (legal),
    .is_copy (is_copy)
  );

  rep_seq_state #(.CW(CW), .AW(AW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .ld_copy  (is_copy),
    .ld_cnt   (in_cnt),
    .ld_src   (in_src),
    .ld_dst   (in_dst),
    .inc      (inc),
    .dec      (dec),
    .copy_q   (copy_q),
    .cnt_q    (uop_cnt),
    .src_q    (uop_src),
    .dst_q    (uop_dst),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  rep_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .legal     (legal),
    .copy_q    (copy_q),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .uop_ready (uop_ready),
    .accept    (accept),
    .refuse_q  (in_refuse),
    .busy      (busy),
    .valid_q   (uop_valid),
    .op_out    (uop_op),
    .inc       (inc),
    .dec       (dec)
  );
endmodule

// File: rtl/rep_seq_chk.sv
module rep_seq_chk
  import rep_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_refuse,
  input logic          busy,
  input logic          uop_valid,
  input logic          uop_ready,
  input logic [2:0]    uop_op,
  input logic [AW-1:0] uop_src,
  input logic [AW-1:0] uop_dst,
  input logic [CW-1:0] uop_cnt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_src) && $stable(uop_dst) && $stable(uop_cnt)); // R8
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> busy); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    busy && in_valid |=> !in_refuse); // R9
  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_refuse |-> !busy); // R2
  AST_LOAD_THEN_STORE: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_ready && uop_op == UOP_LOAD |=> uop_valid && uop_op == UOP_STORE); // R3
  AST_INC_THEN_DEC: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_ready && uop_op == UOP_PTRINC |=> uop_valid && uop_op == UOP_CNTDEC); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_ready && uop_op == UOP_CNTDEC |=> uop_cnt == $past(uop_cnt) - CW'(1)); // R6
  AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_ready && uop_op == UOP_PTRINC |=> uop_dst == $past(uop_dst) + AW'(1)); // R5
endmodule

bind rep_seq rep_seq_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_refuse (in_refuse),
  .busy      (busy),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_op    (uop_op),
  .uop_src   (uop_src),
  .uop_dst   (uop_dst),
  .uop_cnt   (uop_cnt)
);

// File: tb/test_rep_seq.sv
module test_rep_seq;
  localparam int CW = 16;
  localparam int AW = 16;

  typedef struct {
    logic [2:0]    op;
    logic [AW-1:0] s;
    logic [AW-1:0] d;
    logic [CW-1:0] c;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_rep = 1'b0, uop_ready = 1'b1;
  logic [1:0] in_kind = 2'd0;
  logic [CW-1:0] in_cnt = '0;
  logic [AW-1:0] in_src = '0, in_dst = '0;
  logic in_refuse, busy, uop_valid;
  logic [2:0] uop_op;
  logic [AW-1:0] uop_src, uop_dst;
  logic [CW-1:0] uop_cnt;

  int checks = 0, fails = 0, emitted = 0;
  bit stall_mode = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  item_t expq[$];

  always #5 clk = ~clk;

  rep_seq #(.CW(CW), .AW(AW)) i_rep_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_rep(in_rep), .in_kind(in_kind),
    .in_cnt(in_cnt), .in_src(in_src), .in_dst(in_dst), .in_refuse(in_refuse),
    .busy(busy), .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
    .uop_src(uop_src), .uop_dst(uop_dst), .uop_cnt(uop_cnt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ready driver: changes 2 ns after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    uop_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: pops the scoreboard on each hand-off
  always @(negedge clk) begin
    if (!rst) begin
      if (uop_valid && !busy) chk(1'b0, "R10 valid without busy", 1, 0);
      if (uop_valid && uop_ready) begin
        emitted++;
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected micro-op", uop_op, 0);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(uop_op == e.op, "R3/R4 op", uop_op, e.op);
          chk(uop_src == e.s, "R5 src", uop_src, e.s);
          chk(uop_dst == e.d, "R5 dst", uop_dst, e.d);
          chk(uop_cnt == e.c, "R6 cnt", uop_cnt, e.c);
        end
      end
    end
  end

  task automatic expect_loop(input bit copy, input logic [CW-1:0] c,
                             input logic [AW-1:0] s, input logic [AW-1:0] d);
    for (int i = 0; i < int'(c); i++) begin
      logic [AW-1:0] si, di, sn, dn;
      logic [CW-1:0] ci;
      si = copy ? s + AW'(i) : s;
      di = d + AW'(i);
      sn = copy ? si + AW'(1) : s;
      dn = di + AW'(1);
      ci = c - CW'(i);
      if (copy) expq.push_back('{3'd1, si, di, ci});
      expq.push_back('{3'd2, si, di, ci});
      expq.push_back('{3'd3, si, di, ci});
      expq.push_back('{3'd4, sn, dn, ci});
    end
  endtask

  task automatic issue(input bit rep, input logic [1:0] kind, input logic [CW-1:0] c,
                       input logic [AW-1:0] s, input logic [AW-1:0] d, input bit poke);
    bit legal;
    int start, busy_cycles;
    legal = rep && (kind == 2'd1 || kind == 2'd2);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = emitted;
    if (legal) expect_loop(kind == 2'd1, c, s, d);
    in_valid = 1'b1; in_rep = rep; in_kind = kind; in_cnt = c; in_src = s; in_dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (!legal) begin
      chk(in_refuse == 1'b1, "R2 refuse pulse", in_refuse, 1);
      chk(busy == 1'b0, "R2 busy stays low", busy, 0);
      @(negedge clk);
      chk(in_refuse == 1'b0, "R2 refuse one cycle", in_refuse, 0);
      chk(emitted == start, "R2 no micro-op", emitted - start, 0);
      return;
    end
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    busy_cycles = 1;
    if (poke) begin
      in_valid = 1'b1; in_rep = 1'b1; in_kind = 2'd2; in_cnt = 16'd9;
      @(negedge clk);
      busy_cycles++;
      in_kind = 2'd3;
      @(negedge clk);
      busy_cycles++;
      in_valid = 1'b0;
      chk(in_refuse == 1'b0, "R9 no refuse while busy", in_refuse, 0);
    end
    while (busy) begin
      @(negedge clk);
      if (busy) busy_cycles++;
    end
    chk(expq.size() == 0, "R3/R4/R8 all micro-ops delivered", expq.size(), 0);
    chk(emitted - start == int'(c) * ((kind == 2'd1) ? 4 : 3), "R3/R4 micro-op total",
        emitted - start, int'(c) * ((kind == 2'd1) ? 4 : 3));
    if (c == 0) chk(busy_cycles == 2, "R7 zero-count busy length", busy_cycles, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(uop_valid == 1'b0, "R1 valid at reset", uop_valid, 0);
    chk(in_refuse == 1'b0, "R1 refuse at reset", in_refuse, 0);
    rst = 1'b0;
    issue(1'b1, 2'd1, 16'd3, 16'h1000, 16'h2000, 1'b0);   // R3 copy
    issue(1'b1, 2'd2, 16'd4, 16'h0050, 16'h0300, 1'b0);   // R4 fill
    issue(1'b1, 2'd1, 16'd0, 16'h0001, 16'h0002, 1'b0);   // R7 zero copy
    issue(1'b1, 2'd2, 16'd0, 16'h0001, 16'h0002, 1'b0);   // R7 zero fill
    issue(1'b0, 2'd1, 16'd5, 16'h0000, 16'h0000, 1'b0);   // R2 no repeat flag
    issue(1'b1, 2'd3, 16'd5, 16'h0000, 16'h0000, 1'b0);   // R2 other kind
    issue(1'b1, 2'd0, 16'd5, 16'h0000, 16'h0000, 1'b0);   // R2 other kind
    issue(1'b1, 2'd1, 16'd1, 16'hFFFF, 16'hFFFF, 1'b0);   // R5 pointer wrap
    issue(1'b1, 2'd1, 16'd5, 16'h0400, 16'h0800, 1'b1);   // R9 input while busy
    stall_mode = 1'b1;
    issue(1'b1, 2'd1, 16'd20, 16'h0A00, 16'h0B00, 1'b0);  // R8 stalls on copy
    issue(1'b1, 2'd2, 16'd25, 16'h0C00, 16'h0D00, 1'b1);  // R8 stalls on fill
    issue(1'b1, 2'd1, 16'd1, 16'h0010, 16'h0020, 1'b0);   // R6 single iteration
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule